// File: doc/BRIEF.md
# Serial Register Port with Staged DAC Update

This block is a slave serial port that sits between a host controller and a bank of configuration registers. The host raises the enable line, clocks sixteen bits over the serial clock (least significant bit first), and lowers the enable line again. The first bit chooses read or write, the next seven bits are the address, and the last eight bits are data. A write frame updates the addressed configuration byte. A read frame turns the data pin around after the address and sends back the addressed byte.

All serial inputs are brought into the system clock domain through synchronizer flops, and edges of the serial clock are found there. A 14-bit DAC word, together with a mode bit and a calibration bit, is split over two write addresses. Writing the upper half only stages it. Both halves reach the outputs together when the lower half is written, so the analog side never sees a half-updated value. Two read-only addresses give a status byte from outside the block and a fixed identity byte. Every other address is write-only and reads back as zero.

Top module: `serial_reg_port`

## Requirements
- R1: While `sen` is high, each rising edge of `sclk` shifts in one bit of `sdata_in`. Frame bit 0 (first) is the read flag (0 = write, 1 = read). Bits 1..7 are the address, LSB first. Bits 8..15 are the data byte, LSB first.
- R2: A complete write frame to an address from 2 to NUM_WREGS-1 sets byte (address-2) of `cfg_flat`, which is bits [8*(address-2)+7 : 8*(address-2)], to the data byte.
- R3: Only the first 16 rising edges of a frame are counted. Further `sclk` edges before `sen` falls do not change any register, and the bit counter never goes above 16.
- R4: If `sen` falls before the 16th rising edge, the frame is dropped and no register or output changes.
- R5: In a read frame, `sdata_oe` is low up to the 8th rising edge and goes high from the following falling edge. `sdata_out` then gives the read byte LSB first, one bit per falling edge, so that the host can sample it on rising edges 9..16. `sdata_oe` returns low once `sen` is low.
- R6: A write to address 0 (DAC upper) only stages its byte. A write to address 1 (DAC lower) updates the lower byte and copies the staged upper byte to the outputs. The DAC outputs change at no other time.
- R7: Upper DAC byte layout: bits 5..0 are `dac_word[13:8]`, bit 6 is `dac_mode` and bit 7 is `dac_cal`. The lower byte is `dac_word[7:0]`.
- R8: Reading address 0x70 returns `status_in`. Reading address 0x7F returns the CHIP_ID parameter (default 0xA5). Writes to either address change nothing.
- R9: Reading any write-only or unmapped address returns 0x00. Writes to unmapped addresses change nothing.
- R10: The bit counter clears whenever `sen` is low, so a frame that follows an aborted one is decoded from its first bit.
- R11: After a synchronous reset, `dac_word`, `dac_mode`, `dac_cal`, `cfg_flat` and `sdata_oe` are all zero, and the staged upper byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| sen | input | 1 | Frame enable, active high |
| sdata_in | input | 1 | Serial data from host (input side of the data pin) |
| sdata_out | output | 1 | Serial read data (output side of the data pin) |
| sdata_oe | output | 1 | Drive enable for the data pin |
| status_in | input | 8 | Byte returned when reading address 0x70 |
| dac_word | output | 14 | Effective DAC code |
| dac_mode | output | 1 | Effective DAC drive mode bit |
| dac_cal | output | 1 | Effective DAC calibration bit |
| cfg_flat | output | 8*(NUM_WREGS-2) | Configuration bytes for addresses 2..NUM_WREGS-1 |

## Verification
The hardest case to reach from the ports is a frame whose clock count is not sixteen, because a host working correctly never sends one. This matters most when such a frame lands between a staged upper DAC write and its lower commit, or is followed at once by a clean frame. The bench builds every frame from a clock-count argument. Its random mix sends short frames of 1 to 15 clocks and long frames of 17 to 20 clocks, with the extra bits inverted, and it aims a large share of the traffic at the two DAC addresses. A reference model then shows whether a stray frame leaked a write, changed the staged byte or threw off the decoding of the next frame.

// File: rtl/serial_reg_port_pkg.sv
// Package: shared widths, address map and types of the serial register port.
// Assumes a 16-bit frame of read flag, 7-bit address and 8-bit data.
package serial_reg_port_pkg;
    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int DAC_W      = 14;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    localparam addr_t DAC_HI_ADDR = 7'h00;
    localparam addr_t DAC_LO_ADDR = 7'h01;
    localparam addr_t STATUS_ADDR = 7'h70;
    localparam addr_t ID_ADDR     = 7'h7F;
endpackage

// File: rtl/srp_sync.sv
// Module: srp_sync
// Brings WIDTH asynchronous inputs into the clk domain through STAGES flops.
// Also gives the value one cycle older, which is used for edge detection.
// Assumes STAGES >= 2 and inputs that are slow compared with clk.
module srp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out,
    output logic [WIDTH-1:0] sync_prev
);
    logic [WIDTH-1:0] chain [STAGES];

    // Synchronizer chain, followed by one extra flop that keeps the older value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            sync_prev <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            sync_prev <= chain[STAGES-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/srp_framer.sv
// Module: srp_framer
// Counts serial clock edges and collects the 16-bit LSB-first frame.
// Issues a one-cycle write strobe after the 16th bit and, for reads,
// shifts the read byte out on falling edges after the address.
// Assumes synchronized inputs and single-cycle rise/fall pulses.
module srp_framer
    import serial_reg_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sen_s,
    input  logic  sdata_s,
    input  logic  sclk_rise,
    input  logic  sclk_fall,
    input  data_t rd_data,
    output addr_t rd_addr,
    output logic  wr_en,
    output addr_t wr_addr,
    output data_t wr_data,
    output cnt_t  bit_cnt,
    output logic  tx_bit,
    output logic  tx_oe
);
    logic [FRAME_BITS-1:0] shreg;
    logic [FRAME_BITS-1:0] shreg_nxt;
    logic                  rd_flag;
    data_t                 tx_reg;

    // The next shift value: the new bit enters at the top and moves down.
    assign shreg_nxt = {sdata_s, shreg[FRAME_BITS-1:1]};

    // Bit counter, shift register, read flag and captured read address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            rd_flag <= 1'b0;
            rd_addr <= '0;
        end else if (!sen_s) begin
            bit_cnt <= '0;
            rd_flag <= 1'b0;
        end else if (sclk_rise && (bit_cnt < cnt_t'(FRAME_BITS))) begin
            shreg   <= shreg_nxt;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == '0) rd_flag <= sdata_s;
            if (bit_cnt == cnt_t'(ADDR_W)) rd_addr <= shreg_nxt[FRAME_BITS-1 -: ADDR_W];
        end
    end

    // Write strobe with address and data, raised after the 16th bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= sen_s && sclk_rise && !rd_flag
                     && (bit_cnt == cnt_t'(FRAME_BITS - 1));
            wr_addr <= shreg_nxt[ADDR_W:1];
            wr_data <= shreg_nxt[FRAME_BITS-1 -: DATA_W];
        end
    end

    // Read turnaround: load on the fall after the address, then shift per fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_reg <= '0;
            tx_oe  <= 1'b0;
        end else if (!sen_s) begin
            tx_oe <= 1'b0;
        end else if (sclk_fall && rd_flag && (bit_cnt >= cnt_t'(ADDR_W + 1))
                     && (bit_cnt < cnt_t'(FRAME_BITS))) begin
            if (bit_cnt == cnt_t'(ADDR_W + 1)) begin
                tx_reg <= rd_data;
                tx_oe  <= 1'b1;
            end else begin
                tx_reg <= tx_reg >> 1;
            end
        end
    end

    assign tx_bit = tx_oe & tx_reg[0];
endmodule

// File: rtl/srp_regfile.sv
// Module: srp_regfile
// Holds the write-only configuration bytes and the two-step DAC register pair.
// Also decodes the read-only status and identity addresses.
// Assumes NUM_WREGS > 2; addresses 0 and 1 are the DAC halves.
module srp_regfile
    import serial_reg_port_pkg::*;
#(
    parameter int    NUM_WREGS = 12,
    parameter data_t CHIP_ID   = 8'hA5,
    localparam int   CFG_N     = NUM_WREGS - 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  addr_t                wr_addr,
    input  data_t                wr_data,
    input  addr_t                rd_addr,
    input  data_t                status_in,
    output data_t                rd_data,
    output logic [DAC_W-1:0]     dac_word,
    output logic                 dac_mode,
    output logic                 dac_cal,
    output logic [CFG_N*8-1:0]   cfg_flat
);
    data_t hi_stage;
    data_t hi_live;
    data_t lo_live;

    // DAC pair: the upper byte is staged, and both go live on a lower write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_stage <= '0;
            hi_live  <= '0;
            lo_live  <= '0;
        end else if (wr_en && (wr_addr == DAC_HI_ADDR)) begin
            hi_stage <= wr_data;
        end else if (wr_en && (wr_addr == DAC_LO_ADDR)) begin
            lo_live <= wr_data;
            hi_live <= hi_stage;
        end
    end

    assign dac_word = {hi_live[5:0], lo_live};
    assign dac_mode = hi_live[6];
    assign dac_cal  = hi_live[7];

    // One byte register for each plain configuration address.
    for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
        localparam addr_t MY_ADDR = addr_t'(g + 2);
        data_t q;
        // Load this byte when a write targets its address.
        always_ff @(posedge clk) begin
            if (!rst_n)                            q <= '0;
            else if (wr_en && (wr_addr == MY_ADDR)) q <= wr_data;
        end
        assign cfg_flat[g*8 +: 8] = q;
    end

    // Read decode: only the status and identity addresses can be read.
    always_comb begin
        case (rd_addr)
            STATUS_ADDR: rd_data = status_in;
            ID_ADDR:     rd_data = CHIP_ID;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/serial_reg_port.sv
// Module: serial_reg_port (top)
// Slave serial register port with an LSB-first 16-bit frame and a staged
// DAC update. Serial inputs are synchronized to clk and sclk edges are
// found there, so sclk must be slower than about clk/8.
module serial_reg_port
    import serial_reg_port_pkg::*;
#(
    parameter int    NUM_WREGS   = 12,
    parameter int    SYNC_STAGES = 2,
    parameter data_t CHIP_ID     = 8'hA5,
    localparam int   CFG_W       = (NUM_WREGS - 2) * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             sen,
    input  logic             sdata_in,
    output logic             sdata_out,
    output logic             sdata_oe,
    input  logic [7:0]       status_in,
    output logic [13:0]      dac_word,
    output logic             dac_mode,
    output logic             dac_cal,
    output logic [CFG_W-1:0] cfg_flat
);
    logic [2:0] s_now;
    logic [2:0] s_old;
    logic       sen_s;
    logic       sclk_rise;
    logic       sclk_fall;
    addr_t      rd_addr;
    data_t      rd_data;
    logic       wr_en;
    addr_t      wr_addr;
    data_t      wr_data;
    cnt_t       bit_cnt;

    srp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({sdata_in, sen, sclk}),
        .sync_out(s_now), .sync_prev(s_old)
    );

    assign sen_s     = s_now[1];
    assign sclk_rise = s_now[0] & ~s_old[0];
    assign sclk_fall = ~s_now[0] & s_old[0];

    srp_framer u_framer (
        .clk(clk), .rst_n(rst_n), .sen_s(sen_s), .sdata_s(s_now[2]),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .rd_data(rd_data),
        .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bit_cnt(bit_cnt), .tx_bit(sdata_out), .tx_oe(sdata_oe)
    );

    srp_regfile #(.NUM_WREGS(NUM_WREGS), .CHIP_ID(CHIP_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .status_in(status_in),
        .rd_data(rd_data), .dac_word(dac_word), .dac_mode(dac_mode),
        .dac_cal(dac_cal), .cfg_flat(cfg_flat)
    );
endmodule

// File: rtl/serial_reg_port_chk.sv
// Module: serial_reg_port_chk
// Protocol and ordering properties of serial_reg_port, attached by bind.
module serial_reg_port_chk
    import serial_reg_port_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        sen_s,
    input cnt_t        bit_cnt,
    input logic        wr_en,
    input addr_t       wr_addr,
    input logic        sdata_oe,
    input logic [13:0] dac_word,
    input logic        dac_mode,
    input logic        dac_cal
);
    assert_cnt_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= cnt_t'(FRAME_BITS));

    assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sen_s |=> bit_cnt == '0);

    assert_write_full_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> bit_cnt == cnt_t'(FRAME_BITS));

    assert_dac_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == DAC_LO_ADDR) |=>
            ($stable(dac_word) && $stable(dac_mode) && $stable(dac_cal)));

    assert_oe_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sen_s |=> !sdata_oe);

    assert_oe_after_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe) |-> bit_cnt == cnt_t'(ADDR_W + 1));
endmodule

bind serial_reg_port serial_reg_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sen_s(sen_s), .bit_cnt(bit_cnt),
    .wr_en(wr_en), .wr_addr(wr_addr), .sdata_oe(sdata_oe),
    .dac_word(dac_word), .dac_mode(dac_mode), .dac_cal(dac_cal)
);

// File: tb/serial_reg_port_tb.sv
// Bench for serial_reg_port: directed corner cases plus a seeded random mix,
// checked against a reference model kept in the bench.
module serial_reg_port_tb;
    localparam int NW    = 12;
    localparam int CFG_W = (NW - 2) * 8;
    localparam int HALF  = 8;
    localparam logic [7:0] ID = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sen = 1'b0, sdata_in = 1'b0;
    logic sdata_out, sdata_oe;
    logic [7:0] status_in = 8'h00;
    logic [13:0] dac_word;
    logic dac_mode, dac_cal;
    logic [CFG_W-1:0] cfg_flat;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] m_cfg [2:NW-1];
    logic [7:0] m_stage, m_hi, m_lo;

    always #2.5 clk = ~clk;

    serial_reg_port #(.NUM_WREGS(NW), .CHIP_ID(ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sen(sen), .sdata_in(sdata_in),
        .sdata_out(sdata_out), .sdata_oe(sdata_oe), .status_in(status_in),
        .dac_word(dac_word), .dac_mode(dac_mode), .dac_cal(dac_cal),
        .cfg_flat(cfg_flat)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CFG_W-1:0] exp_cfg();
        logic [CFG_W-1:0] v;
        for (int a = 2; a < NW; a++) v[(a-2)*8 +: 8] = m_cfg[a];
        return v;
    endfunction

    function automatic logic [7:0] exp_read(input logic [6:0] a);
        if (a == 7'h70) return status_in;
        if (a == 7'h7F) return ID;
        return 8'h00;
    endfunction

    // Model update for a frame of nclk clocks.
    task automatic model_frame(input bit rw, input logic [6:0] a, input logic [7:0] d,
                               input int nclk);
        if (nclk < 16 || rw) return;
        if (a == 7'h00) m_stage = d;
        else if (a == 7'h01) begin m_lo = d; m_hi = m_stage; end
        else if (a >= 2 && a < NW) m_cfg[a] = d;
    endtask

    // Sends one frame; bits past the 16th are the inverse of the frame bits.
    task automatic send(input bit rw, input logic [6:0] a, input logic [7:0] d,
                        input int nclk, output logic [7:0] rdv,
                        output logic oe_early, output logic oe_mid);
        logic [15:0] bits;
        bits = {d, a, rw};
        rdv = 8'h00; oe_early = 1'b0; oe_mid = 1'b0;
        sen = 1'b1;
        tick(HALF);
        for (int i = 0; i < nclk; i++) begin
            sdata_in = (i < 16) ? bits[i] : ~bits[i % 16];
            tick(HALF);
            if (i == 7) oe_early = sdata_oe;
            if (i == 8) oe_mid = sdata_oe;
            if (i >= 8 && i < 16) rdv[i-8] = sdata_out;
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
        tick(HALF);
        sen = 1'b0;
        tick(HALF + 6);
        model_frame(rw, a, d, nclk);
    endtask

    task automatic check_state(input string req);
        check(cfg_flat == exp_cfg(), {req, " cfg"}, 32'(cfg_flat[31:0]),
              32'(exp_cfg() >> 0));
        check({dac_cal, dac_mode, dac_word} == {m_hi, m_lo}, {req, " dac"},
              32'({dac_cal, dac_mode, dac_word}), 32'({m_hi, m_lo}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic oe_e, oe_m;
        void'($urandom(32'd4711));
        for (int a = 2; a < NW; a++) m_cfg[a] = 8'h00;
        m_stage = 8'h00; m_hi = 8'h00; m_lo = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R11: reset state
        check(sdata_oe == 1'b0, "R11 oe", 32'(sdata_oe), 0);
        check_state("R11");

        // R1 R2: plain write
        send(1'b0, 7'd5, 8'h96, 16, rv, oe_e, oe_m);
        check_state("R1 R2 write addr5");

        // R6: upper DAC byte only staged
        send(1'b0, 7'd0, 8'hC5, 16, rv, oe_e, oe_m);
        check(dac_word == 14'h0 && !dac_mode && !dac_cal, "R6 staged only",
              32'({dac_cal, dac_mode, dac_word}), 0);
        // R6 R7: lower write commits both halves, field layout
        send(1'b0, 7'd1, 8'h3C, 16, rv, oe_e, oe_m);
        check(dac_word == 14'h053C && dac_mode && dac_cal, "R7 layout",
              32'({dac_cal, dac_mode, dac_word}), 32'h0C53C);
        check_state("R6 commit");

        // R4: short frame aborted
        send(1'b0, 7'd3, 8'h77, 10, rv, oe_e, oe_m);
        check_state("R4 abort");

        // R3: long frame, extra clocks ignored
        send(1'b0, 7'd4, 8'h5A, 20, rv, oe_e, oe_m);
        check_state("R3 extra clocks");

        // R5 R8: read identity with turnaround timing
        send(1'b1, 7'h7F, 8'h00, 16, rv, oe_e, oe_m);
        check(rv == ID, "R8 id read", 32'(rv), 32'(ID));
        check(oe_e == 1'b0, "R5 oe before turnaround", 32'(oe_e), 0);
        check(oe_m == 1'b1, "R5 oe after turnaround", 32'(oe_m), 1);
        check(sdata_oe == 1'b0, "R5 oe released", 32'(sdata_oe), 0);

        // R8: status read
        status_in = 8'h3B;
        send(1'b1, 7'h70, 8'h00, 16, rv, oe_e, oe_m);
        check(rv == 8'h3B, "R8 status read", 32'(rv), 32'h3B);

        // R8: writes to read-only addresses change nothing
        send(1'b0, 7'h7F, 8'h11, 16, rv, oe_e, oe_m);
        send(1'b0, 7'h70, 8'h22, 16, rv, oe_e, oe_m);
        send(1'b1, 7'h7F, 8'h00, 16, rv, oe_e, oe_m);
        check(rv == ID, "R8 id unchanged", 32'(rv), 32'(ID));
        check_state("R8 ro write");

        // R9: write-only read is zero; unmapped write ignored
        send(1'b1, 7'd5, 8'h00, 16, rv, oe_e, oe_m);
        check(rv == 8'h00, "R9 write-only read", 32'(rv), 0);
        send(1'b0, 7'h40, 8'hEE, 16, rv, oe_e, oe_m);
        check_state("R9 unmapped write");

        // R10: aborted frame then a clean frame
        send(1'b0, 7'd1, 8'hFF, 5, rv, oe_e, oe_m);
        send(1'b0, 7'd9, 8'hC3, 16, rv, oe_e, oe_m);
        check_state("R10 fresh frame");

        // Random mix aimed at DAC addresses and odd frame lengths
        for (int k = 0; k < 70; k++) begin
            bit rw;
            logic [6:0] a;
            logic [7:0] d;
            int n, sel;
            rw  = ($urandom % 4) == 0;
            sel = $urandom % 6;
            a = (sel == 0) ? 7'd0 : (sel == 1) ? 7'd1 :
                (sel == 2) ? 7'(2 + $urandom % (NW - 2)) :
                (sel == 3) ? 7'h70 : (sel == 4) ? 7'h7F : 7'($urandom);
            d = 8'($urandom);
            sel = $urandom % 8;
            n = (sel == 0) ? 1 + $urandom % 15 : (sel == 1) ? 17 + $urandom % 4 : 16;
            status_in = 8'($urandom);
            send(rw, a, d, n, rv, oe_e, oe_m);
            if (rw && n >= 16)
                check(rv == exp_read(a), "R5 R9 random read", 32'(rv), 32'(exp_read(a)));
            check_state("R2 R3 R4 R6 random");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule